// File: doc/BRIEF.md
# Shared-Counter Multi-Channel PWM Timer

The block is a PWM timer. One up-counter, slowed by a power-of-two prescaler, sets the period for every channel. Each channel compares the counter against its own compare value and drives an edge-aligned PWM output. Software reaches the block through a small register port: a write strobe, a read strobe, a byte address and a 32-bit data word. Reads are combinational while the read strobe is high.

The period and compare values are double-buffered. While the counter runs, a write lands in a holding register and only moves into the active register when the counter wraps, so a period never mixes old and new settings. While the counter is stopped, a write goes straight to the active register. Output-select and polarity changes always act at once. Reads of the period and compare registers return the value currently in use, so software can poll them to see when a buffered write has taken effect.

Register offsets (bytes):
- 0x04: parameter
- 0x10: control
- 0x14: counter
- 0x18: period
- 0x20+8n: channel n control
- 0x24+8n: channel n compare

Top module: `pwm_timer`

## Requirements
- R1: After reset every register reads zero and every output is low. The parameter register at 0x04 always returns the channel count in bits 7:0.
- R2: While the counter runs, it counts 0, 1, … up to the active period and then wraps to 0, giving period+1 counts per cycle. A write of any value to the counter register at 0x14 clears the counter to 0.
- R3: Control register 0x10 holds a prescale value p in bits 2:0 and a run field in bits 4:3. When the run field is nonzero, the counter advances once every 2^p clocks. When it is 00, the counter holds its value.
- R4: While the run field is 00, a write to the period register (0x18) or a channel compare register (0x24+8n) takes effect at once. A read returns the written value.
- R5: While the counter runs, writes to the period and compare registers are held. They are loaded on the clock where the counter wraps, and until then a read returns the old value.
- R6: A channel in normal mode drives its output high while the counter is below its compare value and low otherwise. A compare value of 0 keeps the output low. A compare value above the period keeps it high.
- R7: The 2-bit output select at bits 3:2 of the channel control register is decoded as follows: 10 or 11 gives normal output, 01 gives inverted output, and 00 forces the output low. A change acts on the clock of the write.
- R8: Bit 5 of the channel control register enables PWM mode. While it is 0, the output is low whatever the output select holds.
- R9: Bit 7 of the channel control register is a match flag. It is set when the running counter advances from a value equal to the compare value. Writing 1 to bit 7 clears it; writing 0 leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | 1 | Register write strobe |
| re_i | input | 1 | Register read strobe |
| addr_i | input | ADDR_W | Byte address of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, zero when re_i is low |
| pwm_o | output | N_CH | PWM output, one bit per channel |

## Verification
The assertions check four things on every cycle:
- the counter wraps to zero after the period,
- the counter holds while stopped,
- the active period stays fixed between wraps while running,
- disabled or non-PWM channels stay low, and the match flag rises only after a counter advance.

Only the bench scenarios can show the rest: the exact counter sequence for each prescale setting, the output waveform for every compare value from 0 to above the period in each polarity, the exact wrap at which buffered values appear in readback, and the clear-on-write-one behaviour of the flag.

// File: rtl/pwm_timer_pkg.sv
package pwm_timer_pkg;
  localparam int OFS_PARAM   = 'h04;
  localparam int OFS_CTRL    = 'h10;
  localparam int OFS_COUNT   = 'h14;
  localparam int OFS_PERIOD  = 'h18;
  localparam int OFS_CH_BASE = 'h20;
  localparam int CH_STRIDE   = 8;
  localparam int CH_CMP_OFS  = 4;

  typedef enum logic [1:0] {
    SEL_OFF  = 2'b00,
    SEL_INV  = 2'b01,
    SEL_NORM = 2'b10,
    SEL_ALT  = 2'b11
  } out_sel_e;

  typedef struct packed {
    logic     flag;
    logic     pwm_en;
    logic     mode_a;
    out_sel_e sel;
  } ch_ctl_t;
endpackage

// File: rtl/pwm_timebase.sv
module pwm_timebase #(
  parameter int CNT_W = 16,
  parameter int PSC_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [PSC_W-1:0] psc_i,
  input  logic             clr_i,
  input  logic             per_we_i,
  input  logic [CNT_W-1:0] per_wdata_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] per_o,
  output logic             tick_o,
  output logic             wrap_o
);
  localparam int DIV_W = (1 << PSC_W) - 1;

  logic [DIV_W-1:0] div_q, div_mask;
  logic [CNT_W-1:0] cnt_q, per_q, per_buf_q;

  assign div_mask = ({{(DIV_W-1){1'b0}}, 1'b1} << psc_i) - 1'b1;
  assign tick_o   = run_i && ((div_q & div_mask) == div_mask);
  assign wrap_o   = tick_o && (cnt_q == per_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                div_q <= '0;
    else if (clr_i || !run_i)   div_q <= '0;
    else                        div_q <= div_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clr_i)   cnt_q <= '0;
    else if (wrap_o)  cnt_q <= '0;
    else if (tick_o)  cnt_q <= cnt_q + 1'b1;
  end

  // holding register always takes the write; active copy only when stopped or at wrap
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      per_q     <= '0;
      per_buf_q <= '0;
    end else begin
      if (per_we_i) begin
        per_buf_q <= per_wdata_i;
        if (!run_i) per_q <= per_wdata_i;
      end
      if (wrap_o) per_q <= per_we_i ? per_wdata_i : per_buf_q;
    end
  end

  assign cnt_o = cnt_q;
  assign per_o = per_q;
endmodule

// File: rtl/pwm_channel.sv
module pwm_channel import pwm_timer_pkg::*; #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             tick_i,
  input  logic             wrap_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             ctl_we_i,
  input  logic             cmp_we_i,
  input  logic [31:0]      wdata_i,
  output ch_ctl_t          ctl_o,
  output logic [CNT_W-1:0] cmp_o,
  output logic             pwm_o
);
  ch_ctl_t          ctl_q;
  logic [CNT_W-1:0] cmp_q, cmp_buf_q;
  logic             below;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_q <= '0;
    end else begin
      if (ctl_we_i) begin
        ctl_q.pwm_en <= wdata_i[5];
        ctl_q.mode_a <= wdata_i[4];
        ctl_q.sel    <= out_sel_e'(wdata_i[3:2]);
      end
      // set wins over a simultaneous clear
      if (tick_i && (cnt_i == cmp_q))     ctl_q.flag <= 1'b1;
      else if (ctl_we_i && wdata_i[7])    ctl_q.flag <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmp_q     <= '0;
      cmp_buf_q <= '0;
    end else begin
      if (cmp_we_i) begin
        cmp_buf_q <= wdata_i[CNT_W-1:0];
        if (!run_i) cmp_q <= wdata_i[CNT_W-1:0];
      end
      if (wrap_i) cmp_q <= cmp_we_i ? wdata_i[CNT_W-1:0] : cmp_buf_q;
    end
  end

  assign below = cnt_i < cmp_q;

  always_comb begin
    unique case (ctl_q.sel)
      SEL_OFF: pwm_o = 1'b0;
      SEL_INV: pwm_o = ~below;
      default: pwm_o = below;
    endcase
    if (!ctl_q.pwm_en) pwm_o = 1'b0;
  end

  assign ctl_o = ctl_q;
  assign cmp_o = cmp_q;
endmodule

// File: rtl/pwm_timer.sv
module pwm_timer import pwm_timer_pkg::*; #(
  parameter int N_CH   = 4,
  parameter int CNT_W  = 16,
  parameter int PSC_W  = 3,
  parameter int ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic              re_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic [N_CH-1:0]   pwm_o
);
  localparam int CTRL_W = PSC_W + 3;  // prescale, 2-bit run field, center select

  logic [CTRL_W-1:0] ctrl_q;
  logic [PSC_W-1:0]  psc;
  logic              run, tick, wrap, cnt_clr, per_we;
  logic [CNT_W-1:0]  cnt, per_act;
  logic [31:0]       rd_mux;

  ch_ctl_t           ch_ctl [N_CH];
  logic [CNT_W-1:0]  ch_cmp [N_CH];
  logic [2*N_CH-1:0] ch_sel_flat;
  logic [N_CH-1:0]   ch_pwm_en, ch_flag;

  assign psc     = ctrl_q[PSC_W-1:0];
  assign run     = |ctrl_q[PSC_W+1:PSC_W];
  assign cnt_clr = we_i && (addr_i == ADDR_W'(OFS_COUNT));
  assign per_we  = we_i && (addr_i == ADDR_W'(OFS_PERIOD));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                    ctrl_q <= '0;
    else if (we_i && addr_i == ADDR_W'(OFS_CTRL))   ctrl_q <= wdata_i[CTRL_W-1:0];
  end

  pwm_timebase #(.CNT_W(CNT_W), .PSC_W(PSC_W)) u_timebase (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .run_i       (run),
    .psc_i       (psc),
    .clr_i       (cnt_clr),
    .per_we_i    (per_we),
    .per_wdata_i (wdata_i[CNT_W-1:0]),
    .cnt_o       (cnt),
    .per_o       (per_act),
    .tick_o      (tick),
    .wrap_o      (wrap)
  );

  for (genvar i = 0; i < N_CH; i++) begin : g_ch
    localparam logic [ADDR_W-1:0] CTL_ADDR = ADDR_W'(OFS_CH_BASE + CH_STRIDE * i);
    localparam logic [ADDR_W-1:0] CMP_ADDR = ADDR_W'(OFS_CH_BASE + CH_STRIDE * i + CH_CMP_OFS);

    pwm_channel #(.CNT_W(CNT_W)) u_ch (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .run_i    (run),
      .tick_i   (tick),
      .wrap_i   (wrap),
      .cnt_i    (cnt),
      .ctl_we_i (we_i && addr_i == CTL_ADDR),
      .cmp_we_i (we_i && addr_i == CMP_ADDR),
      .wdata_i  (wdata_i),
      .ctl_o    (ch_ctl[i]),
      .cmp_o    (ch_cmp[i]),
      .pwm_o    (pwm_o[i])
    );

    assign ch_sel_flat[2*i +: 2] = ch_ctl[i].sel;
    assign ch_pwm_en[i]          = ch_ctl[i].pwm_en;
    assign ch_flag[i]            = ch_ctl[i].flag;
  end

  always_comb begin
    rd_mux = '0;
    if (addr_i == ADDR_W'(OFS_PARAM))  rd_mux = {24'd0, 8'(N_CH)};
    if (addr_i == ADDR_W'(OFS_CTRL))   rd_mux = 32'(ctrl_q);
    if (addr_i == ADDR_W'(OFS_COUNT))  rd_mux = 32'(cnt);
    if (addr_i == ADDR_W'(OFS_PERIOD)) rd_mux = 32'(per_act);
    for (int i = 0; i < N_CH; i++) begin
      if (addr_i == ADDR_W'(OFS_CH_BASE + CH_STRIDE * i))
        rd_mux = {24'd0, ch_ctl[i].flag, 1'b0, ch_ctl[i].pwm_en, ch_ctl[i].mode_a,
                  ch_ctl[i].sel, 2'b00};
      if (addr_i == ADDR_W'(OFS_CH_BASE + CH_STRIDE * i + CH_CMP_OFS))
        rd_mux = 32'(ch_cmp[i]);
    end
  end

  assign rdata_o = re_i ? rd_mux : '0;
endmodule

// File: rtl/pwm_timer_chk.sv
module pwm_timer_chk #(
  parameter int N_CH  = 4,
  parameter int CNT_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              run_i,
  input logic              tick_i,
  input logic              wrap_i,
  input logic              clr_i,
  input logic [CNT_W-1:0]  cnt_i,
  input logic [CNT_W-1:0]  per_i,
  input logic [2*N_CH-1:0] sel_i,
  input logic [N_CH-1:0]   pwm_en_i,
  input logic [N_CH-1:0]   flag_i,
  input logic [N_CH-1:0]   pwm_i
);
  assert_wrap_to_zero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap_i |=> (cnt_i == '0));

  assert_hold_when_stopped_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !clr_i) |=> $stable(cnt_i));

  assert_period_fixed_between_wraps_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !wrap_i) |=> $stable(per_i));

  for (genvar i = 0; i < N_CH; i++) begin : g_ch
    assert_off_is_low_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sel_i[2*i +: 2] == 2'b00) |-> !pwm_i[i]);

    assert_no_pwm_mode_low_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !pwm_en_i[i] |-> !pwm_i[i]);

    assert_flag_on_tick_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(flag_i[i]) |-> $past(tick_i));
  end
endmodule

bind pwm_timer pwm_timer_chk #(.N_CH(N_CH), .CNT_W(CNT_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .run_i    (run),
  .tick_i   (tick),
  .wrap_i   (wrap),
  .clr_i    (cnt_clr),
  .cnt_i    (cnt),
  .per_i    (per_act),
  .sel_i    (ch_sel_flat),
  .pwm_en_i (ch_pwm_en),
  .flag_i   (ch_flag),
  .pwm_i    (pwm_o)
);

// File: tb/pwm_timer_tb.sv
`timescale 1ns/1ps
module pwm_timer_tb;
  localparam int N_CH = 4;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        we_i = 1'b0;
  logic        re_i = 1'b0;
  logic [7:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic [N_CH-1:0] pwm_o;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #4 clk_i = ~clk_i;

  pwm_timer #(.N_CH(N_CH)) u_dut (
    .clk_i, .rst_ni, .we_i, .re_i, .addr_i, .wdata_i, .rdata_o, .pwm_o
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    we_i = 1'b1; addr_i = a; wdata_i = d;
    @(posedge clk_i);
    @(negedge clk_i);
    we_i = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    re_i = 1'b1; addr_i = a;
    #1;
    d = rdata_o;
    re_i = 1'b0;
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  function automatic logic [7:0] ctl_a(input int ch); return 8'(32'h20 + 8 * ch); endfunction
  function automatic logic [7:0] cmp_a(input int ch); return 8'(32'h24 + 8 * ch); endfunction

  initial begin
    logic [31:0] d, c0;
    logic [N_CH-1:0] ex;

    step(3);
    rst_ni = 1'b1;
    step(1);

    // R1 reset state and parameter register
    rd(8'h04, d); chk(d[7:0] == 8'(N_CH), "R1 param", d, N_CH);
    rd(8'h10, d); chk(d == 0, "R1 ctrl", d, 0);
    rd(8'h14, d); chk(d == 0, "R1 count", d, 0);
    rd(8'h18, d); chk(d == 0, "R1 period", d, 0);
    for (int ch = 0; ch < N_CH; ch++) begin
      rd(ctl_a(ch), d); chk(d == 0, "R1 ch ctl", d, 0);
      rd(cmp_a(ch), d); chk(d == 0, "R1 ch cmp", d, 0);
    end
    chk(pwm_o == 0, "R1 outputs", pwm_o, 0);

    // R4 immediate writes while stopped
    wr(8'h18, 5); rd(8'h18, d); chk(d == 5, "R4 period", d, 5);
    wr(cmp_a(0), 3); rd(cmp_a(0), d); chk(d == 3, "R4 cmp", d, 3);

    // R2 R3 counter sequence for each prescale value
    for (int p = 0; p < 4; p++) begin
      wr(8'h14, 0);
      rd(8'h14, d); chk(d == 0, "R2 clear", d, 0);
      wr(8'h10, 32'h08 | p);
      for (int k = 1; k <= 6 * (1 << p) + 3; k++) begin
        step(1);
        rd(8'h14, d);
        chk(d == ((k >> p) % 6), "R2 R3 count", d, (k >> p) % 6);
      end
      wr(8'h10, 0);
      rd(8'h14, c0);
      step(3);
      rd(8'h14, d); chk(d == c0, "R3 stopped hold", d, c0);
    end

    // R6 R7 R8 output sweep over compare values
    wr(ctl_a(0), 32'h28);
    wr(ctl_a(1), 32'h24);
    wr(ctl_a(2), 32'h2C);
    for (int c = 0; c < 8; c++) begin
      wr(8'h10, 0);
      for (int ch = 0; ch < N_CH; ch++) wr(cmp_a(ch), c);
      wr(ctl_a(3), (c % 2 == 0) ? 32'h20 : 32'h08);
      wr(8'h14, 0);
      wr(8'h10, 32'h08);
      for (int k = 1; k <= 12; k++) begin
        step(1);
        rd(8'h14, d);
        ex[0] = (d < c);
        ex[1] = !(d < c);
        ex[2] = (d < c);
        ex[3] = 1'b0;
        chk(pwm_o[0] == ex[0], "R6 normal", pwm_o[0], ex[0]);
        chk(pwm_o[1] == ex[1], "R7 inverted", pwm_o[1], ex[1]);
        chk(pwm_o[2] == ex[2], "R7 select 11", pwm_o[2], ex[2]);
        chk(pwm_o[3] == 1'b0, "R7 R8 disabled low", pwm_o[3], 0);
      end
    end

    // R5 buffered updates while running
    wr(8'h10, 0);
    wr(8'h18, 5);
    wr(8'h14, 0);
    wr(cmp_a(0), 2);
    wr(ctl_a(0), 32'h28);
    wr(8'h10, 32'h08);          // k=0
    step(2);                    // k=2
    wr(8'h18, 9);               // k=3
    wr(cmp_a(0), 7);            // k=4
    rd(8'h18, d); chk(d == 5, "R5 period held", d, 5);
    rd(cmp_a(0), d); chk(d == 2, "R5 cmp held", d, 2);
    chk(pwm_o[0] == 1'b0, "R5 old cmp in use", pwm_o[0], 0);
    step(2);                    // k=6, wrapped
    rd(8'h18, d); chk(d == 9, "R5 period loaded", d, 9);
    rd(cmp_a(0), d); chk(d == 7, "R5 cmp loaded", d, 7);
    chk(pwm_o[0] == 1'b1, "R5 new cmp output", pwm_o[0], 1);
    step(9);                    // k=15
    rd(8'h14, d); chk(d == 9, "R5 new period reach", d, 9);
    step(1);                    // k=16
    rd(8'h14, d); chk(d == 0, "R5 new period wrap", d, 0);

    // R7 polarity acts immediately
    wr(ctl_a(0), 32'h24);       // k=17, count 1
    rd(8'h14, d);
    chk(pwm_o[0] == !(d < 7), "R7 immediate invert", pwm_o[0], !(d < 7));
    chk(d == 1, "R7 count phase", d, 1);

    // R9 match flag
    rd(ctl_a(0), d); chk(d[7] == 1'b1, "R9 flag set", d[7], 1);
    wr(ctl_a(0), 32'hA4);       // k=18
    rd(ctl_a(0), d); chk(d == 32'h24, "R9 flag cleared", d, 32'h24);
    step(8);                    // k=26, count passed 7 at k=24
    rd(ctl_a(0), d); chk(d[7] == 1'b1, "R9 flag reset on match", d[7], 1);
    wr(ctl_a(0), 32'h24);       // k=27, write zero to flag
    rd(ctl_a(0), d); chk(d == 32'hA4, "R9 write zero keeps flag", d, 32'hA4);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end
endmodule